// File: doc/BRIEF.md
# Program-Cycle and Write-Protect Controller for a Serial EEPROM

This block sits behind the serial front end of a small byte-wide non-volatile memory. It receives already-decoded events from that front end: a command code at the start of a frame, an address byte, data bytes, and a frame-end event. The frame-end event carries a flag saying whether chip select rose at the legal spot right after the last data bit. From these events, and from a write-permit pin, it decides whether a program operation may run.

When an operation is allowed, it runs a self-timed program cycle and then drives write strobes into a behavioural storage array. It holds a write-enable latch, two block-protect bits that select which address range is locked, a busy flag, and a small page buffer. It presents a status byte that the front end shifts out for a status read.

The program time is a parameter in system clocks. It defaults to 10 ms at 100 MHz. The page size and address width are parameters as well.

Top module: `eeprom_prog_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, busy is low and no write strobe is issued (block-protect bits reset to `BP_RESET`, default 00).
- R2: While idle the status byte is {4'b0000, bp[1:0], wel, 1'b0}: bit 0 is busy, bit 1 is the enable latch, bit 2 is the low protect bit and bit 3 is the high protect bit.
- R3: Command codes on `cmd_i` are 1 enable, 2 disable, 3 status read, 4 status write, 5 array write, 6 array read, 0 none. Code 1 sets the enable latch and code 2 clears it, both in the cycle after `cmd_vld_i`.
- R4: A status write or array write starts a program cycle only if, at the frame-end event, `wr_permit_i` is high and the enable latch is set. Otherwise the frame is dropped: busy stays low and neither the array nor the protect bits change.
- R5: A program cycle starts only on a frame-end event with `end_ok_i` high. A frame ending with `end_ok_i` low is discarded.
- R6: After a commit, busy is high for `PROG_CYCLES` cycles of timing plus `PAGE_BYTES` cycles of array strobing, and then drops. While busy, the status byte reads 0xFF.
- R7: An array write latches the address byte. Data bytes then fill slots whose low log2(`PAGE_BYTES`) address bits increment and wrap while the upper bits stay fixed, so byte `PAGE_BYTES+1` overwrites the first slot. Only slots that received a byte are written to the array.
- R8: With bp=00 nothing is locked; bp=01 locks the top quarter (0xC0-0xFF for 8-bit addresses); bp=10 locks the top half (0x80-0xFF); bp=11 locks every address. No strobe is issued to a locked address.
- R9: A status write takes bits 3 and 2 of its first data byte as the new high and low protect bits, applied when its program cycle ends. All other bits of that byte are ignored.
- R10: The enable latch is cleared when any program cycle ends.
- R11: While busy, a frame of any command other than status read is ignored, including its frame-end commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_permit_i | input | 1 | High permits program operations |
| cmd_vld_i | input | 1 | One-cycle pulse: new frame, command code valid |
| cmd_i | input | 3 | Decoded command code |
| addr_vld_i | input | 1 | One-cycle pulse: address byte valid |
| addr_i | input | ADDR_W | Address byte |
| data_vld_i | input | 1 | One-cycle pulse: data byte valid |
| data_i | input | 8 | Data byte |
| end_vld_i | input | 1 | One-cycle pulse: chip select released |
| end_ok_i | input | 1 | Release came right after a complete byte |
| status_o | output | 8 | Status byte for the status read |
| busy_o | output | 1 | Program cycle in progress |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
The assertions assume the following about the front end:
- Each event input is a one-cycle pulse.
- A frame is opened by `cmd_vld_i` and closed by exactly one `end_vld_i`.
- Address and data pulses belong to the frame opened last.

The stimulus keeps within this contract. It drives every pulse from a falling clock edge, holds it for exactly one cycle, and never overlaps two event pulses. It holds the permit pin steady across each frame-end event it checks.

// File: rtl/eepc_pkg.sv
package eepc_pkg;
   typedef enum logic [2:0] {
      CMD_NONE  = 3'd0,
      CMD_WEN   = 3'd1,
      CMD_WDIS  = 3'd2,
      CMD_STRD  = 3'd3,
      CMD_STWR  = 3'd4,
      CMD_ARWR  = 3'd5,
      CMD_ARRD  = 3'd6
   } cmd_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_TIME  = 2'd1,
      PH_DRAIN = 2'd2
   } phase_e;

   localparam logic [7:0] BUSY_STATUS = 8'hFF;
endpackage

// File: rtl/eepc_range_guard.sv
module eepc_range_guard #(
   parameter int ADDR_W = 8
) (
   input  logic [1:0]        bp_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              locked_o
);
   if (ADDR_W < 2) begin : g_bad_width
      $error("eepc_range_guard: ADDR_W must be at least 2");
   end

   logic top_half;
   logic top_quarter;

   assign top_half    = addr_i[ADDR_W-1];
   assign top_quarter = addr_i[ADDR_W-1] & addr_i[ADDR_W-2];

   always_comb begin
      unique case (bp_i)
         2'b00:   locked_o = 1'b0;
         2'b01:   locked_o = top_quarter;
         2'b10:   locked_o = top_half;
         default: locked_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/eepc_page_buffer.sv
module eepc_page_buffer #(
   parameter int ADDR_W     = 8,
   parameter int PAGE_BYTES = 4
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          clr_i,
   input  logic                          load_addr_i,
   input  logic [ADDR_W-1:0]             addr_i,
   input  logic                          load_data_i,
   input  logic [7:0]                    data_i,
   input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx_i,
   output logic [ADDR_W-1:0]             rd_addr_o,
   output logic [7:0]                    rd_data_o,
   output logic                          rd_valid_o,
   output logic                          any_valid_o
);
   localparam int IDX_W = $clog2(PAGE_BYTES);

   if (PAGE_BYTES < 2 || (1 << IDX_W) != PAGE_BYTES) begin : g_bad_page
      $error("eepc_page_buffer: PAGE_BYTES must be a power of two >= 2");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("eepc_page_buffer: ADDR_W must exceed log2(PAGE_BYTES)");
   end

   logic [ADDR_W-1:IDX_W]  base_q;
   logic [IDX_W-1:0]       ptr_q;
   logic [7:0]             slot_data [PAGE_BYTES];
   logic [PAGE_BYTES-1:0]  slot_vld;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         base_q <= '0;
         ptr_q  <= '0;
      end else if (load_addr_i) begin
         base_q <= addr_i[ADDR_W-1:IDX_W];
         ptr_q  <= addr_i[IDX_W-1:0];
      end else if (load_data_i) begin
         ptr_q  <= ptr_q + 1'b1;
      end
   end

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      logic [7:0] byte_q;
      logic       vld_q;
      logic       hit;

      assign hit = load_data_i && (ptr_q == IDX_W'(g));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            byte_q <= '0;
            vld_q  <= 1'b0;
         end else if (clr_i || load_addr_i) begin
            vld_q  <= 1'b0;
         end else if (hit) begin
            byte_q <= data_i;
            vld_q  <= 1'b1;
         end
      end

      assign slot_data[g] = byte_q;
      assign slot_vld[g]  = vld_q;
   end

   assign rd_addr_o   = {base_q, rd_idx_i};
   assign rd_data_o   = slot_data[rd_idx_i];
   assign rd_valid_o  = slot_vld[rd_idx_i];
   assign any_valid_o = |slot_vld;
endmodule

// File: rtl/eepc_prog_timer.sv
module eepc_prog_timer #(
   parameter int PROG_CYCLES = 1_000_000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic expire_o
);
   localparam int CNT_W = $clog2(PROG_CYCLES + 1);

   if (PROG_CYCLES < 1) begin : g_bad_time
      $error("eepc_prog_timer: PROG_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (start_i) begin
         cnt_q <= CNT_W'(PROG_CYCLES);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/eeprom_prog_ctrl.sv
module eeprom_prog_ctrl
   import eepc_pkg::*;
#(
   parameter int         ADDR_W      = 8,
   parameter int         PAGE_BYTES  = 4,
   parameter int         PROG_CYCLES = 1_000_000,
   parameter logic [1:0] BP_RESET    = 2'b00
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_permit_i,
   input  logic              cmd_vld_i,
   input  logic [2:0]        cmd_i,
   input  logic              addr_vld_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              data_vld_i,
   input  logic [7:0]        data_i,
   input  logic              end_vld_i,
   input  logic              end_ok_i,
   output logic [7:0]        status_o,
   output logic              busy_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [7:0]        mem_wdata_o
);
   localparam int IDX_W = $clog2(PAGE_BYTES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_BYTES - 1);

   if (ADDR_W < 2 || ADDR_W > 24) begin : g_bad_addr
      $error("eeprom_prog_ctrl: ADDR_W out of range");
   end

   phase_e           phase_q;
   logic [IDX_W-1:0] drain_q;
   logic             wel_q;
   logic [1:0]       bp_q;
   logic             op_sr_q;

   cmd_e             frm_cmd_q;
   logic             frm_live_q;
   logic             addr_seen_q;
   logic             sr_seen_q;
   logic [7:0]       sr_byte_q;

   cmd_e             cmd_in;
   logic             addr_take;
   logic             data_take;
   logic             sr_take;
   logic             buf_clr;
   logic             commit_ok;
   logic             expire;
   logic             drain_last;

   logic [ADDR_W-1:0] rd_addr;
   logic [7:0]        rd_data;
   logic              rd_valid;
   logic              any_valid;
   logic              rd_locked;

   assign cmd_in     = cmd_e'(cmd_i);
   assign busy_o     = (phase_q != PH_IDLE);
   assign buf_clr    = cmd_vld_i && !busy_o;
   assign addr_take  = addr_vld_i && frm_live_q && (frm_cmd_q == CMD_ARWR) && !addr_seen_q;
   assign data_take  = data_vld_i && frm_live_q && (frm_cmd_q == CMD_ARWR) && addr_seen_q;
   assign sr_take    = data_vld_i && frm_live_q && (frm_cmd_q == CMD_STWR) && !sr_seen_q;
   assign drain_last = (phase_q == PH_DRAIN) && (drain_q == LAST_IDX);

   always_comb begin
      commit_ok = 1'b0;
      if (end_vld_i && end_ok_i && frm_live_q && !busy_o && wr_permit_i && wel_q) begin
         commit_ok = ((frm_cmd_q == CMD_ARWR) && any_valid)
                  || ((frm_cmd_q == CMD_STWR) && sr_seen_q);
      end
   end

   // frame tracking
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         frm_cmd_q   <= CMD_NONE;
         frm_live_q  <= 1'b0;
         addr_seen_q <= 1'b0;
         sr_seen_q   <= 1'b0;
         sr_byte_q   <= '0;
      end else if (cmd_vld_i) begin
         frm_cmd_q   <= cmd_in;
         frm_live_q  <= !busy_o;
         addr_seen_q <= 1'b0;
         sr_seen_q   <= 1'b0;
      end else if (end_vld_i) begin
         frm_live_q  <= 1'b0;
      end else begin
         if (addr_take) addr_seen_q <= 1'b1;
         if (sr_take) begin
            sr_seen_q <= 1'b1;
            sr_byte_q <= data_i;
         end
      end
   end

   // enable latch and protect bits
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wel_q <= 1'b0;
         bp_q  <= BP_RESET;
      end else begin
         if (cmd_vld_i && !busy_o && cmd_in == CMD_WEN) begin
            wel_q <= 1'b1;
         end else if (cmd_vld_i && !busy_o && cmd_in == CMD_WDIS) begin
            wel_q <= 1'b0;
         end else if (drain_last) begin
            wel_q <= 1'b0;
         end
         if (drain_last && op_sr_q) begin
            bp_q <= sr_byte_q[3:2];
         end
      end
   end

   // program cycle sequencer
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_IDLE;
         drain_q <= '0;
         op_sr_q <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE: if (commit_ok) begin
               phase_q <= PH_TIME;
               op_sr_q <= (frm_cmd_q == CMD_STWR);
            end
            PH_TIME: if (expire) begin
               phase_q <= PH_DRAIN;
               drain_q <= '0;
            end
            PH_DRAIN: begin
               if (drain_last) phase_q <= PH_IDLE;
               drain_q <= drain_q + 1'b1;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   eepc_prog_timer #(
      .PROG_CYCLES (PROG_CYCLES)
   ) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (commit_ok),
      .expire_o (expire)
   );

   eepc_page_buffer #(
      .ADDR_W     (ADDR_W),
      .PAGE_BYTES (PAGE_BYTES)
   ) u_page (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (buf_clr),
      .load_addr_i (addr_take),
      .addr_i      (addr_i),
      .load_data_i (data_take),
      .data_i      (data_i),
      .rd_idx_i    (drain_q),
      .rd_addr_o   (rd_addr),
      .rd_data_o   (rd_data),
      .rd_valid_o  (rd_valid),
      .any_valid_o (any_valid)
   );

   eepc_range_guard #(
      .ADDR_W (ADDR_W)
   ) u_guard (
      .bp_i     (bp_q),
      .addr_i   (rd_addr),
      .locked_o (rd_locked)
   );

   assign mem_we_o    = (phase_q == PH_DRAIN) && !op_sr_q && rd_valid && !rd_locked;
   assign mem_addr_o  = rd_addr;
   assign mem_wdata_o = rd_data;
   assign status_o    = busy_o ? BUSY_STATUS : {4'b0000, bp_q, wel_q, 1'b0};
endmodule

// File: rtl/eepc_prog_ctrl_chk.sv
module eepc_prog_ctrl_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wr_permit_i,
   input logic              end_vld_i,
   input logic [7:0]        status_o,
   input logic              busy_o,
   input logic              mem_we_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [1:0]        bp_i
);
   a_r6_busy_reads_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> (status_o == 8'hFF));

   a_r6_strobe_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_we_o |-> busy_o);

   a_r8_no_strobe_all_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_we_o |-> (bp_i != 2'b11));

   a_r8_no_strobe_upper_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_we_o && bp_i == 2'b10) |-> !mem_addr_o[ADDR_W-1]);

   a_r10_latch_clear_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> !status_o[1]);

   a_r4_no_start_without_permit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (end_vld_i && !wr_permit_i && !busy_o) |=> !busy_o);

   a_r9_bp_steady_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |=> $stable(bp_i));
endmodule

bind eeprom_prog_ctrl eepc_prog_ctrl_chk #(
   .ADDR_W (ADDR_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .wr_permit_i (wr_permit_i),
   .end_vld_i   (end_vld_i),
   .status_o    (status_o),
   .busy_o      (busy_o),
   .mem_we_o    (mem_we_o),
   .mem_addr_o  (mem_addr_o),
   .bp_i        (bp_q)
);

// File: tb/eeprom_prog_ctrl_tb.sv
module eeprom_prog_ctrl_tb;
   localparam int ADDR_W = 8;
   localparam int PAGE   = 4;
   localparam int PCYC   = 40;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             permit = 1'b1;
   logic             cmd_vld = 1'b0;
   logic [2:0]       cmd = 3'd0;
   logic             addr_vld = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic             data_vld = 1'b0;
   logic [7:0]       data = '0;
   logic             end_vld = 1'b0;
   logic             end_ok = 1'b0;
   logic [7:0]       status;
   logic             busy;
   logic             mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [7:0]       mem_wdata;

   logic [7:0] arr [256];
   logic [7:0] exp_arr [256];
   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   eeprom_prog_ctrl #(
      .ADDR_W (ADDR_W), .PAGE_BYTES (PAGE), .PROG_CYCLES (PCYC), .BP_RESET (2'b00)
   ) u_dut (
      .clk_i (clk), .rst_ni (rst_n), .wr_permit_i (permit),
      .cmd_vld_i (cmd_vld), .cmd_i (cmd),
      .addr_vld_i (addr_vld), .addr_i (addr),
      .data_vld_i (data_vld), .data_i (data),
      .end_vld_i (end_vld), .end_ok_i (end_ok),
      .status_o (status), .busy_o (busy),
      .mem_we_o (mem_we), .mem_addr_o (mem_addr), .mem_wdata_o (mem_wdata)
   );

   always @(posedge clk) if (mem_we) arr[mem_addr] <= mem_wdata;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic pulse_cmd(input logic [2:0] c);
      @(negedge clk); cmd_vld = 1'b1; cmd = c;
      @(negedge clk); cmd_vld = 1'b0;
   endtask

   task automatic pulse_addr(input logic [7:0] a);
      @(negedge clk); addr_vld = 1'b1; addr = a;
      @(negedge clk); addr_vld = 1'b0;
   endtask

   task automatic pulse_data(input logic [7:0] d);
      @(negedge clk); data_vld = 1'b1; data = d;
      @(negedge clk); data_vld = 1'b0;
   endtask

   task automatic pulse_end(input logic ok);
      @(negedge clk); end_vld = 1'b1; end_ok = ok;
      @(negedge clk); end_vld = 1'b0; end_ok = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic wr_frame(input logic [7:0] a, input int n, input logic [7:0] b [5], input logic ok);
      pulse_cmd(3'd5);
      pulse_addr(a);
      for (int i = 0; i < n; i++) pulse_data(b[i]);
      pulse_end(ok);
   endtask

   task automatic sr_frame(input logic [7:0] d);
      pulse_cmd(3'd4);
      pulse_data(d);
      pulse_end(1'b1);
   endtask

   task automatic chk_mem(input string req, input logic [7:0] a);
      chk(req, {24'd0, arr[a]}, {24'd0, exp_arr[a]});
   endtask

   task automatic t_reset;
      chk("R1 status", {24'd0, status}, 32'h00);
      chk("R1 busy", {31'd0, busy}, 32'd0);
      chk("R1 strobe", {31'd0, mem_we}, 32'd0);
   endtask

   task automatic t_enable;
      pulse_cmd(3'd1);
      chk("R3 R2 enable sets bit1", {24'd0, status}, 32'h02);
      pulse_cmd(3'd2);
      chk("R3 disable clears bit1", {24'd0, status}, 32'h00);
   endtask

   task automatic t_no_permit;
      logic [7:0] b [5] = '{8'hAA, 0, 0, 0, 0};
      pulse_cmd(3'd1);
      permit = 1'b0;
      wr_frame(8'h10, 1, b, 1'b1);
      chk("R4 pin low no busy", {31'd0, busy}, 32'd0);
      permit = 1'b1;
      pulse_cmd(3'd2);
      wr_frame(8'h10, 1, b, 1'b1);
      chk("R4 latch clear no busy", {31'd0, busy}, 32'd0);
      repeat (3) @(negedge clk);
      chk_mem("R4 array untouched", 8'h10);
   endtask

   task automatic t_misaligned;
      logic [7:0] b [5] = '{8'h77, 0, 0, 0, 0};
      pulse_cmd(3'd1);
      wr_frame(8'h12, 1, b, 1'b0);
      chk("R5 misaligned no busy", {31'd0, busy}, 32'd0);
      chk_mem("R5 array untouched", 8'h12);
      pulse_cmd(3'd2);
   endtask

   task automatic t_single;
      logic [7:0] b [5] = '{8'h5A, 0, 0, 0, 0};
      int n;
      pulse_cmd(3'd1);
      wr_frame(8'h21, 1, b, 1'b1);
      chk("R6 status ones while busy", {24'd0, status}, 32'hFF);
      wait_idle(n);
      chk("R6 busy length", n, PCYC + PAGE);
      exp_arr[8'h21] = 8'h5A;
      chk_mem("R7 single byte", 8'h21);
      chk_mem("R7 neighbour", 8'h20);
      chk("R10 latch cleared", {24'd0, status}, 32'h00);
   endtask

   task automatic t_wrap;
      logic [7:0] b [5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
      int n;
      pulse_cmd(3'd1);
      wr_frame(8'h46, 5, b, 1'b1);
      wait_idle(n);
      exp_arr[8'h46] = 8'h55; exp_arr[8'h47] = 8'h22;
      exp_arr[8'h44] = 8'h33; exp_arr[8'h45] = 8'h44;
      for (int i = 8'h44; i <= 8'h47; i++) chk_mem("R7 page wrap", 8'(i));
      chk_mem("R7 outside page", 8'h48);
   endtask

   task automatic t_partial;
      logic [7:0] b [5] = '{8'h66, 8'h77, 0, 0, 0};
      int n;
      arr[8'h48] = 8'hC3; exp_arr[8'h48] = 8'hC3;
      pulse_cmd(3'd1);
      wr_frame(8'h49, 2, b, 1'b1);
      wait_idle(n);
      exp_arr[8'h49] = 8'h66; exp_arr[8'h4A] = 8'h77;
      for (int i = 8'h48; i <= 8'h4B; i++) chk_mem("R7 only loaded slots", 8'(i));
   endtask

   task automatic prot_write(input logic [7:0] a, input logic [7:0] d, input bit locked);
      logic [7:0] b [5] = '{d, 0, 0, 0, 0};
      int n;
      pulse_cmd(3'd1);
      wr_frame(a, 1, b, 1'b1);
      wait_idle(n);
      if (!locked) exp_arr[a] = d;
      chk_mem(locked ? "R8 locked address kept" : "R8 open address written", a);
   endtask

   task automatic set_bp(input logic [7:0] d, input logic [7:0] exp_status);
      int n;
      pulse_cmd(3'd1);
      sr_frame(d);
      wait_idle(n);
      chk("R9 status write", {24'd0, status}, {24'd0, exp_status});
   endtask

   task automatic t_protect;
      set_bp(8'hF4, 8'h04);
      prot_write(8'hC3, 8'h01, 1'b1);
      prot_write(8'hB0, 8'h02, 1'b0);
      set_bp(8'h08, 8'h08);
      prot_write(8'h90, 8'h03, 1'b1);
      prot_write(8'h7F, 8'h04, 1'b0);
      set_bp(8'h0C, 8'h0C);
      prot_write(8'h05, 8'h05, 1'b1);
      set_bp(8'hF3, 8'h00);
      prot_write(8'hFF, 8'h06, 1'b0);
   endtask

   task automatic t_busy_ignore;
      logic [7:0] b1 [5] = '{8'hAA, 0, 0, 0, 0};
      logic [7:0] b2 [5] = '{8'hBB, 0, 0, 0, 0};
      int n;
      pulse_cmd(3'd1);
      wr_frame(8'h30, 1, b1, 1'b1);
      pulse_cmd(3'd1);
      wr_frame(8'h31, 1, b2, 1'b1);
      wait_idle(n);
      exp_arr[8'h30] = 8'hAA;
      chk_mem("R11 first write done", 8'h30);
      repeat (3) @(negedge clk);
      chk("R11 no second cycle", {31'd0, busy}, 32'd0);
      chk_mem("R11 busy-time write dropped", 8'h31);
      chk("R11 latch stays clear", {24'd0, status}, 32'h00);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin arr[i] = 8'h00; exp_arr[i] = 8'h00; end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_no_permit();
      t_misaligned();
      t_single();
      t_wrap();
      t_partial();
      t_protect();
      t_busy_ignore();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule